// File: doc/BRIEF.md
# Slave Processor Host Interface

This block lets an external master processor trade single bytes with the local core over an 8-bit parallel slave bus. The master side has a chip select, a command/data line and either two active-low strobes (one for reading, one for writing) or, when the mode input selects it, one active-low data strobe plus a read/write direction line. Every master input is passed through a two-flop synchronizer into the core clock. Strobe ends are found as edges of the synchronized activity signals, and each strobe pulse produces exactly one buffer event.

The input buffer holds a byte from a master write, together with a tag. The tag is the level of the command/data line during that write. The output buffer holds a byte that the core loads. The master reads it with command/data low. With command/data high, the master instead reads a status byte in which bit 0 is the input-full flag and bit 1 is the output-full flag.

The handshake output `hb_sta` goes high after a master write and low after a master data read. The core gets a one-cycle interrupt pulse for each committed master write. It also gets a one-cycle pulse each time a master data read empties the output buffer. Read data is driven only while a read strobe is active; `hb_doe` is the tri-state enable for the pad.

Top module: `hostif_slave`

## Requirements
- R1: While `rst_n` is low at a clock edge, `in_full`, `out_full`, `hb_sta` and both interrupt outputs are 0 after that edge. `hb_doe` is 0 while no read strobe is active.
- R2: With `mode_ds`=0 and `hb_cs_n` low, a low pulse on `hb_wr_n` stores `hb_din` in `core_rdata` and the level of `hb_cd` in `core_rcmd`, and sets `in_full`.
- R3: With `mode_ds`=1 and `hb_cs_n` low, a low pulse on `hb_ds_n` while `hb_rnw`=0 performs the write of R2. A low pulse on `hb_ds_n` while `hb_rnw`=1 performs a read.
- R4: A strobe pulse while `hb_cs_n` is high has no effect: `in_full` stays 0 and no interrupt pulses.
- R5: `hb_sta` is still unchanged after the second rising clock edge that follows a write strobe's return to high. It is 1 after the third such edge.
- R6: `hb_doe` is 1 only while `hb_cs_n` is low and a read is active (`hb_rd_n` low in mode 0; `hb_ds_n` low with `hb_rnw`=1 in mode 1). `hb_dout` then shows the output buffer when `hb_cd`=0, and {6'b0, out_full, in_full} when `hb_cd`=1.
- R7: A `core_wr_en` cycle loads `core_wdata` and sets `out_full`. A master read with `hb_cd`=0 clears `out_full` and drops `hb_sta` on the third edge after its strobe ends. A read with `hb_cd`=1 changes neither.
- R8: `core_rd_en` clears `in_full` on the next edge. A master write committing on the same edge wins, and `in_full` stays 1.
- R9: `irq_in_full` is a one-cycle pulse for each committed master write. `irq_out_empty` is a one-cycle pulse when a master data read clears `out_full`.
- R10: A strobe held low for many cycles produces exactly one buffer event and one interrupt pulse.
- R11: A `core_wr_en` on the same edge as a master data-read event wins. `out_full` stays 1 and the new byte is what the master reads next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_ds | input | 1 | 0: separate read/write strobes; 1: data strobe plus read/write line |
| hb_cs_n | input | 1 | Master chip select, active low |
| hb_cd | input | 1 | Command(1)/data(0) select from master |
| hb_rd_n | input | 1 | Master read strobe, mode 0 |
| hb_wr_n | input | 1 | Master write strobe, mode 0 |
| hb_ds_n | input | 1 | Master data strobe, mode 1 |
| hb_rnw | input | 1 | Direction in mode 1: 1 read, 0 write |
| hb_din | input | 8 | Byte from master |
| hb_dout | output | 8 | Byte to master, 0 when not enabled |
| hb_doe | output | 1 | Output enable for the slave bus pad |
| hb_sta | output | 1 | Handshake status to master |
| core_wr_en | input | 1 | Core loads the output buffer |
| core_wdata | input | 8 | Byte for the output buffer |
| core_rd_en | input | 1 | Core takes the input buffer |
| core_rdata | output | 8 | Input buffer byte |
| core_rcmd | output | 1 | Command/data tag of the input buffer byte |
| in_full | output | 1 | Input buffer holds an unread byte |
| out_full | output | 1 | Output buffer holds a byte the master has not read |
| irq_in_full | output | 1 | One-cycle pulse per master write |
| irq_out_empty | output | 1 | One-cycle pulse when the master empties the output buffer |

## Verification
The bench aims at same-edge collisions between core and master. A design where the core clear beats a master write would lose the byte and show `in_full` low. One where a master read beats a core load would report an empty buffer that holds fresh data.

It holds a write strobe low for twenty cycles; a level-triggered event would fire interrupts repeatedly. It pins the handshake to the exact edge, which catches a missing or extra synchronizer stage. It also reads status with the command line high, to catch a design that lets any read empty the output buffer or drop the handshake. Strobes with chip select high, and a write in data-strobe mode, must not turn on the bus driver.

// File: rtl/hostif_pkg.sv
// Package: shared constants and the bus-mode encoding for the host interface.
// Assumes a byte-wide slave bus and a two-flop synchronizer depth.
package hostif_pkg;
    localparam int HB_DW       = 8;
    localparam int SYNC_STAGES = 2;
    localparam int CTRL_BITS   = 6;

    typedef enum logic {
        BUS_RDWR = 1'b0,
        BUS_DSRW = 1'b1
    } bus_mode_e;
endpackage

// File: rtl/hostif_sync.sv
// Module: multi-stage synchronizer for a bundle of asynchronous master pins.
// Assumes pins are quasi-static across a strobe so bits may be sampled as a group.
module hostif_sync #(
    parameter int          W       = 14,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // Shift the sampled pins through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/hostif_strobe.sv
// Module: decodes the synchronized master pins into read/write activity for
// the selected bus mode and emits a one-cycle event when a strobe ends.
// Assumes cd and data are valid for the whole active phase of a strobe.
module hostif_strobe
    import hostif_pkg::*;
#(
    parameter int DW = HB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  bus_mode_e     mode,
    input  logic          cs_n,
    input  logic          cd,
    input  logic          rd_n,
    input  logic          wr_n,
    input  logic          ds_n,
    input  logic          rnw,
    input  logic [DW-1:0] din,
    output logic          rd_done,
    output logic          wr_done,
    output logic          ev_cd,
    output logic [DW-1:0] ev_data
);
    logic rd_act, wr_act;
    logic rd_q, wr_q;

    // Activity decode for the two strobe protocols.
    always_comb begin
        if (mode == BUS_DSRW) begin
            rd_act = !cs_n && !ds_n && rnw;
            wr_act = !cs_n && !ds_n && !rnw;
        end else begin
            rd_act = !cs_n && !rd_n;
            wr_act = !cs_n && !wr_n;
        end
    end

    // Remember last cycle's activity, tag and byte for end-of-strobe events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q    <= 1'b0;
            wr_q    <= 1'b0;
            ev_cd   <= 1'b0;
            ev_data <= '0;
        end else begin
            rd_q    <= rd_act;
            wr_q    <= wr_act;
            ev_cd   <= cd;
            ev_data <= din;
        end
    end

    assign rd_done = rd_q && !rd_act;
    assign wr_done = wr_q && !wr_act;
endmodule

// File: rtl/hostif_bufs.sv
// Module: input and output byte buffers, their full flags, the handshake
// status and the core interrupt pulses. Same-edge conflicts favour the
// side that fills a buffer.
module hostif_bufs #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_done,
    input  logic          rd_done,
    input  logic          ev_cd,
    input  logic [DW-1:0] ev_data,
    input  logic          core_wr_en,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_rd_en,
    output logic [DW-1:0] in_data,
    output logic          in_cmd,
    output logic          in_full,
    output logic [DW-1:0] out_data,
    output logic          out_full,
    output logic          sta,
    output logic          irq_in_full,
    output logic          irq_out_empty
);
    logic data_rd;
    assign data_rd = rd_done && !ev_cd;

    // Input buffer: master fills, core drains; a fill wins a collision.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_full <= 1'b0;
            in_data <= '0;
            in_cmd  <= 1'b0;
        end else if (wr_done) begin
            in_full <= 1'b1;
            in_data <= ev_data;
            in_cmd  <= ev_cd;
        end else if (core_rd_en) begin
            in_full <= 1'b0;
        end
    end

    // Output buffer: core fills, a master data read drains; a fill wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_full <= 1'b0;
            out_data <= '0;
        end else if (core_wr_en) begin
            out_full <= 1'b1;
            out_data <= core_wdata;
        end else if (data_rd) begin
            out_full <= 1'b0;
        end
    end

    // Handshake status: raised by a master write, dropped by a data read.
    always_ff @(posedge clk) begin
        if (!rst_n)       sta <= 1'b0;
        else if (wr_done) sta <= 1'b1;
        else if (data_rd) sta <= 1'b0;
    end

    // One-cycle interrupt pulses to the core.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_in_full   <= 1'b0;
            irq_out_empty <= 1'b0;
        end else begin
            irq_in_full   <= wr_done;
            irq_out_empty <= data_rd && out_full && !core_wr_en;
        end
    end
endmodule

// File: rtl/hostif_slave.sv
// Module: top of the slave processor host interface. Synchronizes the master
// pins, detects strobe ends, keeps the buffers and drives the read bus.
// Assumes mode_ds is static configuration; the read path is combinational
// from the raw pins so data is on the bus while the strobe is low.
module hostif_slave
    import hostif_pkg::*;
#(
    parameter int DW = HB_DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mode_ds,
    input  logic          hb_cs_n,
    input  logic          hb_cd,
    input  logic          hb_rd_n,
    input  logic          hb_wr_n,
    input  logic          hb_ds_n,
    input  logic          hb_rnw,
    input  logic [DW-1:0] hb_din,
    output logic [DW-1:0] hb_dout,
    output logic          hb_doe,
    output logic          hb_sta,
    input  logic          core_wr_en,
    input  logic [DW-1:0] core_wdata,
    input  logic          core_rd_en,
    output logic [DW-1:0] core_rdata,
    output logic          core_rcmd,
    output logic          in_full,
    output logic          out_full,
    output logic          irq_in_full,
    output logic          irq_out_empty
);
    localparam int SW = CTRL_BITS + DW;

    bus_mode_e     mode;
    logic [SW-1:0] raw_bus, syn_bus;
    logic          s_cs_n, s_cd, s_rd_n, s_wr_n, s_ds_n, s_rnw;
    logic [DW-1:0] s_din, ev_data, out_data;
    logic          rd_done, wr_done, ev_cd;
    logic          rd_live;

    assign mode    = bus_mode_e'(mode_ds);
    assign raw_bus = {hb_cs_n, hb_cd, hb_rd_n, hb_wr_n, hb_ds_n, hb_rnw, hb_din};

    hostif_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL({SW{1'b1}})) u_sync (
        .clk (clk),
        .rst_n (rst_n),
        .d (raw_bus),
        .q (syn_bus)
    );

    assign {s_cs_n, s_cd, s_rd_n, s_wr_n, s_ds_n, s_rnw, s_din} = syn_bus;

    hostif_strobe #(.DW(DW)) u_strobe (
        .clk (clk),
        .rst_n (rst_n),
        .mode (mode),
        .cs_n (s_cs_n),
        .cd (s_cd),
        .rd_n (s_rd_n),
        .wr_n (s_wr_n),
        .ds_n (s_ds_n),
        .rnw (s_rnw),
        .din (s_din),
        .rd_done (rd_done),
        .wr_done (wr_done),
        .ev_cd (ev_cd),
        .ev_data (ev_data)
    );

    hostif_bufs #(.DW(DW)) u_bufs (
        .clk (clk),
        .rst_n (rst_n),
        .wr_done (wr_done),
        .rd_done (rd_done),
        .ev_cd (ev_cd),
        .ev_data (ev_data),
        .core_wr_en (core_wr_en),
        .core_wdata (core_wdata),
        .core_rd_en (core_rd_en),
        .in_data (core_rdata),
        .in_cmd (core_rcmd),
        .in_full (in_full),
        .out_data (out_data),
        .out_full (out_full),
        .sta (hb_sta),
        .irq_in_full (irq_in_full),
        .irq_out_empty (irq_out_empty)
    );

    // Read-bus drive: enabled only during an active read strobe.
    always_comb begin
        if (mode == BUS_DSRW) rd_live = !hb_cs_n && !hb_ds_n && hb_rnw;
        else                  rd_live = !hb_cs_n && !hb_rd_n;
        hb_doe  = rd_live;
        hb_dout = '0;
        if (rd_live) hb_dout = hb_cd ? {{(DW-2){1'b0}}, out_full, in_full} : out_data;
    end
endmodule

// File: rtl/hostif_slave_chk.sv
// Module: property checker for hostif_slave, bound to every instance.
// Assumes only the top-level ports; no internal signals are probed.
module hostif_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic hb_cs_n,
    input logic hb_doe,
    input logic hb_sta,
    input logic core_wr_en,
    input logic core_rd_en,
    input logic in_full,
    input logic out_full,
    input logic irq_in_full,
    input logic irq_out_empty
);
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!in_full && !out_full && !hb_sta && !irq_in_full && !irq_out_empty));

    p_irq_with_fill_r2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in_full |-> in_full);

    p_sta_on_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_full) |-> hb_sta);

    p_drive_needs_cs_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hb_doe |-> !hb_cs_n);

    p_core_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        core_wr_en |=> out_full);

    p_drain_by_core_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_full) |-> $past(core_rd_en));

    p_empty_irq_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out_empty |-> !out_full);

    p_one_in_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_in_full |=> !irq_in_full);

    p_one_out_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out_empty |=> !irq_out_empty);
endmodule

bind hostif_slave hostif_slave_chk u_chk (
    .clk (clk),
    .rst_n (rst_n),
    .hb_cs_n (hb_cs_n),
    .hb_doe (hb_doe),
    .hb_sta (hb_sta),
    .core_wr_en (core_wr_en),
    .core_rd_en (core_rd_en),
    .in_full (in_full),
    .out_full (out_full),
    .irq_in_full (irq_in_full),
    .irq_out_empty (irq_out_empty)
);

// File: tb/hostif_slave_tb_top.sv
// Bench: vector-table master writes, then directed reset, timing and
// collision tests for hostif_slave.
module hostif_slave_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mode_ds = 1'b0;
    logic hb_cs_n = 1'b1, hb_cd = 1'b1, hb_rd_n = 1'b1, hb_wr_n = 1'b1;
    logic hb_ds_n = 1'b1, hb_rnw = 1'b1;
    logic [7:0] hb_din = 8'h00;
    logic [7:0] hb_dout;
    logic hb_doe, hb_sta;
    logic core_wr_en = 1'b0, core_rd_en = 1'b0;
    logic [7:0] core_wdata = 8'h00;
    logic [7:0] core_rdata;
    logic core_rcmd, in_full, out_full, irq_in_full, irq_out_empty;

    int n_run = 0, n_fail = 0;
    int n_irq_in = 0, n_irq_out = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    hostif_slave dut_i (
        .clk (clk), .rst_n (rst_n), .mode_ds (mode_ds),
        .hb_cs_n (hb_cs_n), .hb_cd (hb_cd), .hb_rd_n (hb_rd_n), .hb_wr_n (hb_wr_n),
        .hb_ds_n (hb_ds_n), .hb_rnw (hb_rnw), .hb_din (hb_din),
        .hb_dout (hb_dout), .hb_doe (hb_doe), .hb_sta (hb_sta),
        .core_wr_en (core_wr_en), .core_wdata (core_wdata), .core_rd_en (core_rd_en),
        .core_rdata (core_rdata), .core_rcmd (core_rcmd),
        .in_full (in_full), .out_full (out_full),
        .irq_in_full (irq_in_full), .irq_out_empty (irq_out_empty)
    );

    // Count interrupt pulses, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && irq_in_full)   n_irq_in++;
        if (rst_n && irq_out_empty) n_irq_out++;
    end

    // Vector fields: [11] mode, [10] cs_n, [9] cd, [8] expected fill, [7:0] byte.
    localparam logic [11:0] WVEC [6] = '{
        12'h1A5, 12'h33C, 12'h95A, 12'hBFF, 12'h477, 12'hE00
    };

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mwrite(input logic md, input logic csn, input logic cdv,
                          input logic [7:0] d, input int hold);
        @(negedge clk);
        mode_ds = md; hb_cs_n = csn; hb_cd = cdv; hb_din = d;
        if (md) begin hb_rnw = 1'b0; hb_ds_n = 1'b0; end
        else    hb_wr_n = 1'b0;
        repeat (hold) @(negedge clk);
        hb_wr_n = 1'b1; hb_ds_n = 1'b1; hb_rnw = 1'b1; hb_cs_n = 1'b1;
    endtask

    task automatic mread_begin(input logic md, input logic cdv);
        @(negedge clk);
        mode_ds = md; hb_cs_n = 1'b0; hb_cd = cdv;
        if (md) begin hb_rnw = 1'b1; hb_ds_n = 1'b0; end
        else    hb_rd_n = 1'b0;
        #1;
    endtask

    task automatic mread_end();
        repeat (3) @(negedge clk);
        hb_rd_n = 1'b1; hb_ds_n = 1'b1; hb_rnw = 1'b1; hb_cs_n = 1'b1;
    endtask

    task automatic core_write(input logic [7:0] d);
        @(negedge clk); core_wr_en = 1'b1; core_wdata = d;
        @(negedge clk); core_wr_en = 1'b0;
    endtask

    task automatic core_read();
        @(negedge clk); core_rd_en = 1'b1;
        @(negedge clk); core_rd_en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        int b_in, b_out;
        repeat (5) @(negedge clk);
        // R1 reset state
        check("R1 in_full", in_full, 0);
        check("R1 out_full", out_full, 0);
        check("R1 sta", hb_sta, 0);
        check("R1 doe", hb_doe, 0);
        check("R1 irqs", n_irq_in + n_irq_out, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Table of master writes: R2 (mode 0), R3 (mode 1), R4 (cs high)
        for (int i = 0; i < 6; i++) begin
            string tag;
            logic [11:0] v;
            v = WVEC[i];
            tag = v[10] ? "R4" : (v[11] ? "R3" : "R2");
            b_in = n_irq_in;
            mwrite(v[11], v[10], v[9], v[7:0], 3);
            repeat (4) @(negedge clk);
            check({tag, " in_full"}, in_full, v[8]);
            check({tag, " irq"}, n_irq_in - b_in, v[8]);
            if (v[8]) begin
                check({tag, " data"}, core_rdata, v[7:0]);
                check({tag, " tag"}, core_rcmd, v[9]);
            end
            core_read();
            @(negedge clk);
            check("R8 core drain", in_full, 0);
        end

        // R7/R6/R9: core load, master data read empties, sta drops
        core_write(8'h42);
        check("R7 out_full set", out_full, 1);
        b_out = n_irq_out;
        mread_begin(1'b0, 1'b0);
        check("R6 doe mode0", hb_doe, 1);
        check("R6 data byte", hb_dout, 8'h42);
        mread_end();
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R7 sta before 3rd edge", hb_sta, 1);
        @(posedge clk); @(negedge clk);
        check("R7 sta dropped", hb_sta, 0);
        check("R7 out_full cleared", out_full, 0);
        repeat (2) @(negedge clk);
        check("R9 out irq", n_irq_out - b_out, 1);

        // R5: sta edge timing after a write
        mwrite(1'b0, 1'b0, 1'b0, 8'h6B, 3);
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R5 sta after 2 edges", hb_sta, 0);
        @(posedge clk); @(negedge clk);
        check("R5 sta after 3 edges", hb_sta, 1);

        // R6/R7: status read in mode 1 leaves out_full and sta
        core_write(8'h99);
        mread_begin(1'b1, 1'b1);
        check("R6 status byte", hb_dout, 8'h03);
        mread_end();
        repeat (5) @(negedge clk);
        check("R7 status read keeps out_full", out_full, 1);
        check("R7 status read keeps sta", hb_sta, 1);

        // R6: no drive without cs, or during a mode-1 write
        @(negedge clk); mode_ds = 1'b0; hb_cs_n = 1'b1; hb_rd_n = 1'b0; #1;
        check("R6 no drive cs high", hb_doe, 0);
        @(negedge clk); hb_rd_n = 1'b1;
        mwrite(1'b1, 1'b0, 1'b0, 8'h10, 0);
        #1;
        check("R6 no drive on write", hb_doe, 0);
        repeat (5) @(negedge clk);
        core_read();

        // R10: long strobe yields one event
        b_in = n_irq_in;
        mwrite(1'b0, 1'b0, 1'b1, 8'hC3, 20);
        repeat (5) @(negedge clk);
        check("R10 single irq", n_irq_in - b_in, 1);
        check("R10 data", core_rdata, 8'hC3);

        // R8: core drain on the same edge as a master write commit
        mwrite(1'b0, 1'b0, 1'b0, 8'hD7, 3);
        @(posedge clk); @(posedge clk); @(negedge clk);
        core_rd_en = 1'b1;
        @(negedge clk); core_rd_en = 1'b0;
        check("R8 write wins", in_full, 1);
        check("R8 byte", core_rdata, 8'hD7);

        // R11: core load on the same edge as a master data-read event
        core_write(8'h11);
        mread_begin(1'b0, 1'b0);
        mread_end();
        @(posedge clk); @(posedge clk); @(negedge clk);
        core_wr_en = 1'b1; core_wdata = 8'h22;
        @(negedge clk); core_wr_en = 1'b0;
        check("R11 out_full kept", out_full, 1);
        mread_begin(1'b0, 1'b0);
        check("R11 new byte", hb_dout, 8'h22);
        mread_end();
        repeat (5) @(negedge clk);

        // R3: data read in data-strobe mode
        core_write(8'h5C);
        mread_begin(1'b1, 1'b0);
        check("R3 mode1 doe", hb_doe, 1);
        check("R3 mode1 byte", hb_dout, 8'h5C);
        mread_end();
        repeat (5) @(negedge clk);
        check("R3 mode1 drains", out_full, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule